// File: doc/BRIEF.md
# Serial Identifier CRC-8 Checker

This block checks the integrity of a 64-bit device identifier that arrives one bit per strobe from a single-wire bus front end. The low seven bytes of the identifier are folded into an 8-bit CRC, and the top byte is captured as the check value the device sent. After the last bit the block raises a one-cycle `done` together with a pass/fail indication. The block only reports the result. It never stalls or aborts the bus sequence, so the controller decides what to do after a mismatch.

The same shift generator also serves a byte-wide accumulation path. A controller that has sent command, address or data bytes, or has read back a page of data, can push each byte through the generator. It then reads the running CRC on `crc_out` and compares it with the CRC byte the device returned. The byte path continues from whatever value the register holds, so a `start` pulse seeds a new transfer check at zero.

Top module: `idcrc_checker`

## Requirements
- R1: After reset, `done`, `crc_ok`, `byte_busy` and `crc_out` are all 0, and no frame is open: `bit_vld` strobes have no effect on `crc_out` or `done` until a `start` pulse.
- R2: A `start` pulse sets `crc_out` to 0x00 by the next cycle, opens a new 64-bit frame, discards any frame in progress and cancels any byte accumulation in progress.
- R3: Each of the first 56 accepted bits of a frame updates the CRC for the polynomial x^8+x^5+x^4+1. Bits are taken least significant first, with a right shift and the reflected constant 0x8C. The identifier bytes 0x02,0x1C,0xB8,0x01,0x00,0x00,0x00 give 0xA2.
- R4: Accepted bits 57 to 64 leave `crc_out` unchanged and are assembled, least significant first, into the received check byte.
- R5: `done` is high for exactly one cycle, in the cycle after the clock edge that accepts the 64th bit of a frame.
- R6: `crc_ok` is high only together with `done`, and only when the computed CRC equals the received check byte. On a mismatch `crc_ok` stays low while `done` still pulses.
- R7: Once 64 bits have been accepted, further `bit_vld` strobes are ignored until the next `start`.
- R8: A `byte_vld` strobe while idle feeds `byte_in` into the CRC, least significant bit first, one bit per cycle over 8 cycles. The feed starts from the current `crc_out`. `byte_busy` is high for the 7 cycles after the accepting edge, and the final value appears once it falls.
- R9: While `byte_busy` is high, `byte_vld` and `bit_vld` are ignored. If `bit_vld` is accepted in the same cycle as `byte_vld`, the bit wins and the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clear CRC and open a new identifier frame |
| bit_in | input | 1 | Serial identifier bit |
| bit_vld | input | 1 | Qualifies `bit_in` for one cycle |
| byte_in | input | 8 | Transfer byte for CRC accumulation |
| byte_vld | input | 1 | Qualifies `byte_in` for one cycle |
| byte_busy | output | 1 | Byte accumulation in progress |
| done | output | 1 | One-cycle pulse after the 64th identifier bit |
| crc_ok | output | 1 | Computed CRC matched the received check byte (valid with `done`) |
| crc_out | output | 8 | Running CRC register |

## Verification
A wrong step in the shift logic shows on `crc_out` in the cycle after the bad bit. It then persists, because every later value depends on it, so a known identifier ending at anything other than 0xA2 exposes it. A bit counter that is off by one moves the `done` pulse by a cycle, or lets a check-byte bit leak into `crc_out`. These are caught by sampling `done` in the exact cycle after bit 64 and by sampling `crc_out` between bits 56 and 64. A wrong byte-path counter shows as `byte_busy` falling early or late, with a final CRC that differs from the bytewise reference.

// File: rtl/idcrc_checker.sv
module idcrc_checker #(
  parameter int ID_BITS = 64,
  parameter int CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY_R = 8'h8C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             bit_in,
  input  logic             bit_vld,
  input  logic [CRC_W-1:0] byte_in,
  input  logic             byte_vld,
  output logic             byte_busy,
  output logic             done,
  output logic             crc_ok,
  output logic [CRC_W-1:0] crc_out
);

  localparam int DATA_BITS = ID_BITS - CRC_W;
  localparam int CNT_W = $clog2(ID_BITS + 1);
  localparam int BCNT_W = $clog2(CRC_W + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(ID_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ID_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_BODY = CNT_W'(DATA_BITS);
  localparam logic [BCNT_W-1:0] BCNT_LOAD = BCNT_W'(CRC_W - 1);

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    crc_step = (c >> 1) ^ ({CRC_W{c[0] ^ b}} & POLY_R);
  endfunction

  logic [CRC_W-1:0]  crc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CRC_W-1:0]  rx_q;
  logic [CRC_W-1:0]  sh_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic              done_q;
  logic              ok_q;

  logic              frame_act;
  logic              bit_take;
  logic              byte_take;
  logic              last_bit;
  logic              in_body;
  logic [CRC_W-1:0]  rx_next;

  assign byte_busy = bcnt_q != '0;
  assign frame_act = cnt_q < CNT_END;
  assign bit_take  = bit_vld && frame_act && !byte_busy && !start;
  assign byte_take = byte_vld && !byte_busy && !bit_take && !start;
  assign in_body   = cnt_q < CNT_BODY;
  assign last_bit  = bit_take && (cnt_q == CNT_LAST);
  assign rx_next   = {bit_in, rx_q[CRC_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q  <= '0;
      cnt_q  <= CNT_END;
      rx_q   <= '0;
      sh_q   <= '0;
      bcnt_q <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      done_q <= last_bit;
      ok_q   <= last_bit && (crc_q == rx_next);
      if (start) begin
        crc_q  <= '0;
        cnt_q  <= '0;
        rx_q   <= '0;
        bcnt_q <= '0;
      end else if (bit_take) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (in_body) crc_q <= crc_step(crc_q, bit_in);
        else         rx_q  <= rx_next;
      end else if (byte_take) begin
        crc_q  <= crc_step(crc_q, byte_in[0]);
        sh_q   <= byte_in >> 1;
        bcnt_q <= BCNT_LOAD;
      end else if (byte_busy) begin
        crc_q  <= crc_step(crc_q, sh_q[0]);
        sh_q   <= sh_q >> 1;
        bcnt_q <= bcnt_q - BCNT_W'(1);
      end
    end
  end

  assign done    = done_q;
  assign crc_ok  = ok_q;
  assign crc_out = crc_q;

endmodule

// File: rtl/idcrc_checker_sva.sv
module idcrc_checker_sva #(
  parameter int CRC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             bit_vld,
  input logic             byte_vld,
  input logic             byte_busy,
  input logic             done,
  input logic             crc_ok,
  input logic [CRC_W-1:0] crc_out
);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R6
  ok_with_done_chk: assert property (@(posedge clk) disable iff (rst) crc_ok |-> done);

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (crc_out == '0) && !byte_busy && !done);

  // R8
  busy_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(byte_busy) |-> $past(byte_vld));

  // R4
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !bit_vld && !byte_vld && !byte_busy) |=> $stable(crc_out));

  // R9
  busy_hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_busy && !start) |=> !done);

endmodule

bind idcrc_checker idcrc_checker_sva #(.CRC_W(CRC_W)) sva_i (
  .clk(clk), .rst(rst), .start(start), .bit_vld(bit_vld), .byte_vld(byte_vld),
  .byte_busy(byte_busy), .done(done), .crc_ok(crc_ok), .crc_out(crc_out)
);

// File: tb/idcrc_checker_tb.sv
`timescale 1ns/1ps
module idcrc_checker_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       bit_in = 1'b0;
  logic       bit_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       byte_vld = 1'b0;
  logic       byte_busy;
  logic       done;
  logic       crc_ok;
  logic [7:0] crc_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  localparam logic [63:0] GOOD_ID = 64'hA200_0000_01B8_1C02;

  always #2.5 clk = ~clk;

  idcrc_checker dut_i (
    .clk(clk), .rst(rst), .start(start), .bit_in(bit_in), .bit_vld(bit_vld),
    .byte_in(byte_in), .byte_vld(byte_vld), .byte_busy(byte_busy),
    .done(done), .crc_ok(crc_ok), .crc_out(crc_out)
  );

  function automatic logic [7:0] ref_bit(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    ref_bit = {1'b0, c[7:1]};
    if (fb) ref_bit = ref_bit ^ 8'h8C;
  endfunction

  function automatic logic [7:0] ref_byte(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = ref_bit(r, d[i]);
    ref_byte = r;
  endfunction

  function automatic logic [7:0] ref_id(input logic [63:0] id);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < 56; i++) r = ref_bit(r, id[i]);
    ref_id = r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_in = b;
    bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_bits(input logic [63:0] id, input int first, input int last);
    for (int i = first; i <= last; i++) send_bit(id[i]);
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 crc_ok", crc_ok, 0);
    chk("R1 busy", byte_busy, 0);
    chk("R1 crc_out", crc_out, 0);
    for (int i = 0; i < 64; i++) begin
      send_bit(1'b1);
      if (done) chk("R1 done before start", done, 0);
    end
    chk("R1 crc_out ignores bits before start", crc_out, 0);
  endtask

  task automatic t_good_id();
    pulse_start();
    chk("R2 crc cleared", crc_out, 0);
    send_bits(GOOD_ID, 0, 55);
    chk("R3 crc after 56 bits", crc_out, 8'hA2);
    send_bits(GOOD_ID, 56, 59);
    chk("R4 crc held in check byte", crc_out, 8'hA2);
    chk("R5 no early done", done, 0);
    send_bits(GOOD_ID, 60, 63);
    chk("R5 done after bit 64", done, 1);
    chk("R6 crc_ok on match", crc_ok, 1);
    chk("R3 final crc", crc_out, 8'hA2);
    @(negedge clk);
    chk("R5 done single cycle", done, 0);
    chk("R6 crc_ok drops with done", crc_ok, 0);
  endtask

  task automatic t_bad_data();
    logic [63:0] id;
    id = GOOD_ID ^ 64'h0000_0000_0000_0100;
    pulse_start();
    send_bits(id, 0, 63);
    chk("R6 done on mismatch", done, 1);
    chk("R6 crc_ok low on data error", crc_ok, 0);
    chk("R3 crc of corrupted id", crc_out, ref_id(id));
    @(negedge clk);
  endtask

  task automatic t_bad_check();
    logic [63:0] id;
    id = GOOD_ID ^ 64'h8000_0000_0000_0000;
    pulse_start();
    send_bits(id, 0, 63);
    chk("R6 done with bad check byte", done, 1);
    chk("R6 crc_ok low on check byte error", crc_ok, 0);
    chk("R4 crc unaffected by check byte", crc_out, 8'hA2);
    @(negedge clk);
  endtask

  task automatic t_extra_bits();
    logic seen;
    pulse_start();
    send_bits(GOOD_ID, 0, 63);
    seen = 1'b0;
    for (int i = 0; i < 16; i++) begin
      send_bit(1'b1);
      if (done) seen = 1'b1;
    end
    chk("R7 no second done", seen, 0);
    chk("R7 crc unchanged after frame", crc_out, 8'hA2);
  endtask

  task automatic t_restart();
    pulse_start();
    send_bits(64'hFFFF_FFFF_FFFF_FFFF, 0, 19);
    pulse_start();
    chk("R2 restart clears crc", crc_out, 0);
    send_bits(GOOD_ID, 0, 63);
    chk("R2 restarted frame done", done, 1);
    chk("R2 restarted frame ok", crc_ok, 1);
    @(negedge clk);
  endtask

  task automatic feed_byte(input logic [7:0] b, output logic busy7, output logic busy8);
    byte_in = b;
    byte_vld = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0;
    repeat (6) @(negedge clk);
    busy7 = byte_busy;
    @(negedge clk);
    busy8 = byte_busy;
  endtask

  task automatic t_byte_mode();
    logic b7, b8;
    logic [7:0] exp;
    logic [7:0] seq [7];
    seq = '{8'h02, 8'h1C, 8'hB8, 8'h01, 8'h00, 8'h00, 8'h00};
    pulse_start();
    exp = 8'h00;
    for (int i = 0; i < 7; i++) begin
      feed_byte(seq[i], b7, b8);
      exp = ref_byte(exp, seq[i]);
      chk("R8 busy through 7th cycle", b7, 1);
      chk("R8 busy clear after 8th", b8, 0);
      chk("R8 running crc", crc_out, exp);
    end
    chk("R8 bytewise identifier crc", crc_out, 8'hA2);
    feed_byte(8'hA2, b7, b8);
    chk("R8 crc over own check byte is zero", crc_out, 8'h00);
  endtask

  task automatic t_byte_ignore();
    pulse_start();
    byte_in = 8'h5A;
    byte_vld = 1'b1;
    @(negedge clk);
    byte_in = 8'hFF;
    @(negedge clk);
    byte_vld = 1'b0;
    bit_in = 1'b1;
    bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 busy ended", byte_busy, 0);
    chk("R9 strobes during busy ignored", crc_out, ref_byte(8'h00, 8'h5A));
    pulse_start();
    byte_in = 8'hC3;
    byte_vld = 1'b1;
    bit_in = 1'b1;
    bit_vld = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0;
    bit_vld = 1'b0;
    chk("R9 bit wins over byte", byte_busy, 0);
    chk("R9 only the bit stepped", crc_out, ref_bit(8'h00, 1'b1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_good_id();
    t_bad_data();
    t_bad_check();
    t_extra_bits();
    t_restart();
    t_byte_mode();
    t_byte_ignore();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule